// File: doc/BRIEF.md
# SIMD Register Swap Execution Unit

This unit decodes one 32-bit vector-swap instruction word per clock and carries it out on a private file of 32 registers, each 64 bits wide. A mode input selects which of two fixed opcode prefixes is legal. The fixed-width encoding uses prefix `111100111` and the compact-encoding mode uses prefix `111111111`. Size bit 6 picks between exchanging a single 64-bit register and exchanging an aligned pair of registers that forms a 128-bit quadword.

The word's classification is registered on the same rising edge that commits the register writes. The status outputs therefore describe the instruction that was presented in the previous cycle. A word that fails the opcode match is not accepted and has no effect. A word that matches while SIMD execution is disabled, or a quadword form that names an odd register, is flagged undefined and writes nothing. A word whose two register numbers are equal is accepted but flagged unpredictable, and it also leaves the file unchanged. A single load port lets other producers place data in the file. Two combinational read ports expose the contents.

Top module: `vswp_unit`

## Requirements
- R1: A word is recognised when bits 31:23 equal `111100111` with `cmp_mode`=0, or `111111111` with `cmp_mode`=1, and every fixed field below also matches.
- R2: A word is ignored when a fixed field differs from its required value, or when its prefix belongs to the other mode. The fixed fields are bits 21:20=`11`, bits 19:18=`00`, bits 17:16=`10`, bit 11=0, bits 10:7=`0000` and bit 4=0. An ignored word raises no status output and changes no register.
- R3: The first register number is {bit 22, bits 15:12}, and the second is {bit 5, bits 3:0}.
- R4: With bit 6=0 and distinct numbers d and m, register d takes the old contents of m and register m takes the old contents of d. No other register changes.
- R5: With bit 6=1, the pairs d/d+1 and m/m+1 are exchanged element by element, and every read uses the contents from before the instruction.
- R6: A recognised word with `simd_en`=0 sets `undef` and clears `accepted`, and writes nothing.
- R7: A quadword-form word in which bit 12 or bit 0 is 1 (an odd register number) sets `undef` and writes nothing.
- R8: A recognised, enabled, legal word with d equal to m sets both `accepted` and `unpred`, and leaves the file unchanged.
- R9: While `rst` is high at a rising edge, all registers and all status outputs are cleared to zero.
- R10: Every register write of an instruction takes effect on the edge that samples `in_valid`=1. The status outputs are valid for exactly the following cycle, so a new instruction can be issued every cycle.
- R11: With `in_valid`=0, the instruction word has no effect.
- R12: `ld_en`=1 writes `ld_data` into register `ld_addr` at the edge. If a swap writes the same register in that cycle, the swap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| cmp_mode | input | 1 | 0: fixed-width prefix, 1: compact-encoding prefix |
| simd_en | input | 1 | SIMD execution enabled |
| ld_en | input | 1 | Load port write enable |
| ld_addr | input | 5 | Load port register number |
| ld_data | input | 64 | Load port data |
| ra_addr | input | 5 | Read port A register number |
| ra_data | output | 64 | Read port A data (combinational) |
| rb_addr | input | 5 | Read port B register number |
| rb_data | output | 64 | Read port B data (combinational) |
| accepted | output | 1 | Previous-cycle word executed (swap or same-register case) |
| undef | output | 1 | Previous-cycle word was undefined |
| unpred | output | 1 | Previous-cycle word named the same register twice |

## Verification
Each status pulse is due one cycle after the edge that samples its instruction. The register contents are already final after that same edge, because the file and the status register share a single stage. The driver stamps every expected status item with the cycle number at which it falls due. The monitor pops an item only when its stamp matches the current cycle, and it samples on the falling edge. Register contents are compared against a bench model through both read ports during idle stretches, after the last write of each group has committed.

// File: rtl/vswp_pkg.sv
package vswp_pkg;

    localparam int REG_W  = 64;
    localparam int NREGS  = 32;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int INSN_W = 32;

    localparam logic [8:0] PFX_FIXED   = 9'b111100111;
    localparam logic [8:0] PFX_COMPACT = 9'b111111111;

    typedef struct packed {
        logic             hit;
        logic             quad;
        logic [IDX_W-1:0] d;
        logic [IDX_W-1:0] m;
    } swap_dec_t;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_SWAP   = 2'd1,
        ST_UNDEF  = 2'd2,
        ST_UNPRED = 2'd3
    } swap_status_e;

    function automatic logic prefix_ok(input logic [INSN_W-1:0] w, input logic compact);
        return compact ? (w[31:23] == PFX_COMPACT) : (w[31:23] == PFX_FIXED);
    endfunction

    function automatic logic fixed_ok(input logic [INSN_W-1:0] w);
        return (w[21:16] == 6'b110010) && !w[11] && (w[10:7] == 4'b0000) && !w[4];
    endfunction

endpackage

// File: rtl/vswp_decode.sv
module vswp_decode
    import vswp_pkg::*;
#(
    parameter int W = INSN_W
) (
    input  logic [W-1:0] insn,
    input  logic         compact,
    output swap_dec_t    dec
);
    always_comb begin
        dec.hit  = prefix_ok(insn, compact) && fixed_ok(insn);
        dec.quad = insn[6];
        dec.d    = {insn[22], insn[15:12]};
        dec.m    = {insn[5],  insn[3:0]};
    end
endmodule

// File: rtl/vswp_classify.sv
module vswp_classify
    import vswp_pkg::*;
(
    input  logic         valid,
    input  logic         simd_en,
    input  swap_dec_t    dec,
    output swap_status_e status,
    output logic         swap_we
);
    logic odd_quad;
    assign odd_quad = dec.quad && (dec.d[0] || dec.m[0]);

    always_comb begin
        if (!valid || !dec.hit)  status = ST_NONE;
        else if (!simd_en)       status = ST_UNDEF;
        else if (odd_quad)       status = ST_UNDEF;
        else if (dec.d == dec.m) status = ST_UNPRED;
        else                     status = ST_SWAP;
    end

    assign swap_we = (status == ST_SWAP);
endmodule

// File: rtl/vswp_regfile.sv
module vswp_regfile
    import vswp_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int NR = NREGS,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap_we,
    input  logic          quad,
    input  logic [AW-1:0] d,
    input  logic [AW-1:0] m,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    logic [NR-1:0][DW-1:0] rf;
    logic [DW-1:0]         rf_nxt [NR];
    logic [AW-1:0]         d_hi, m_hi;

    assign d_hi = d + AW'(1);
    assign m_hi = m + AW'(1);

    for (genvar i = 0; i < NR; i++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(i);
        assign rf_nxt[i] =
            (swap_we && d == IDX)                ? rf[m]    :
            (swap_we && m == IDX)                ? rf[d]    :
            (swap_we && quad && d_hi == IDX)     ? rf[m_hi] :
            (swap_we && quad && m_hi == IDX)     ? rf[d_hi] :
            (ld_en && ld_addr == IDX)            ? ld_data  :
                                                   rf[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf <= '0;
        end else begin
            for (int i = 0; i < NR; i++) rf[i] <= rf_nxt[i];
        end
    end

    assign ra_data = rf[ra_addr];
    assign rb_data = rf[rb_addr];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !swap_we && !ld_en |=> $stable(rf)) else $error("file changed while idle"); // R11
    AST_SWAP_FIRST: assert property (@(posedge clk) disable iff (rst)
        swap_we |=> rf[$past(d)] == $past(rf[m])) else $error("first register not swapped"); // R4
    AST_SWAP_SECOND: assert property (@(posedge clk) disable iff (rst)
        swap_we |=> rf[$past(m)] == $past(rf[d])) else $error("second register not swapped"); // R4
    AST_SWAP_UPPER: assert property (@(posedge clk) disable iff (rst)
        swap_we && quad |=> rf[$past(d_hi)] == $past(rf[m_hi])) else $error("upper half not swapped"); // R5
endmodule

// File: rtl/vswp_unit.sv
module vswp_unit
    import vswp_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int NR = NREGS,
    parameter int IW = INSN_W,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [IW-1:0] insn,
    input  logic          cmp_mode,
    input  logic          simd_en,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    output logic          accepted,
    output logic          undef,
    output logic          unpred
);
    swap_dec_t    dec;
    swap_status_e st_nxt, st_q;
    logic         swap_we;

    vswp_decode #(.W(IW)) u_dec (
        .insn    (insn),
        .compact (cmp_mode),
        .dec     (dec)
    );

    vswp_classify u_cls (
        .valid   (in_valid),
        .simd_en (simd_en),
        .dec     (dec),
        .status  (st_nxt),
        .swap_we (swap_we)
    );

    vswp_regfile #(.DW(DW), .NR(NR)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .swap_we (swap_we),
        .quad    (dec.quad),
        .d       (dec.d),
        .m       (dec.m),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_NONE;
        else     st_q <= st_nxt;
    end

    assign accepted = (st_q == ST_SWAP) || (st_q == ST_UNPRED);
    assign undef    = (st_q == ST_UNDEF);
    assign unpred   = (st_q == ST_UNPRED);

    AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && dec.hit) |=> !accepted && !undef && !unpred) else $error("status on ignored word"); // R2
    AST_DISABLED_UNDEF: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.hit && !simd_en |=> undef && !accepted) else $error("disabled word not undefined"); // R6
    AST_ODD_QUAD_UNDEF: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.hit && insn[6] && (insn[12] || insn[0]) |=> undef && !accepted) else $error("odd quad not undefined"); // R7
    AST_SAME_REG_UNPRED: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.hit && simd_en && !undef && (insn[22] == insn[5]) && (insn[15:12] == insn[3:0]) |=> unpred && accepted)
        else $error("same-register word not flagged"); // R8
    AST_UNDEF_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(undef && (accepted || unpred))) else $error("undef combined with other status"); // R6
endmodule

// File: tb/vswp_unit_test.sv
module vswp_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn;
    logic        cmp_mode;
    logic        simd_en;
    logic        ld_en;
    logic [4:0]  ld_addr;
    logic [63:0] ld_data;
    logic [4:0]  ra_addr, rb_addr;
    logic [63:0] ra_data, rb_data;
    logic        accepted, undef, unpred;

    always #(CLK_PERIOD/2) clk = ~clk;

    vswp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .cmp_mode(cmp_mode),
        .simd_en(simd_en), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
        .accepted(accepted), .undef(undef), .unpred(unpred)
    );

    typedef struct {
        int    due;
        logic  acc;
        logic  und;
        logic  unp;
        string req;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] mdl [32];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    function automatic logic [31:0] enc(input logic compact, input logic quad, input logic [4:0] d, input logic [4:0] m);
        logic [8:0] pfx;
        pfx = compact ? 9'b111111111 : 9'b111100111;
        return {pfx, d[4], 2'b11, 2'b00, 2'b10, d[3:0], 1'b0, 4'b0000, quad, m[4], 1'b0, m[3:0]};
    endfunction

    // Scoreboard monitor: status is due one cycle after the sampling edge
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            check(it.req, "accepted", 64'(accepted), 64'(it.acc));
            check(it.req, "undef",    64'(undef),    64'(it.und));
            check(it.req, "unpred",   64'(unpred),   64'(it.unp));
        end
    end

    // Driver: called at a falling edge, holds the word for one cycle
    task automatic issue(input logic [31:0] w, input logic compact, input logic en, input logic vld, input string req);
        exp_t        it;
        logic        hit, quad, odd;
        logic [4:0]  d, m;
        logic [63:0] t0, t1;
        in_valid = vld; insn = w; cmp_mode = compact; simd_en = en;
        hit  = vld && (w[31:23] == (compact ? 9'h1FF : 9'h1E7)) && (w[21:16] == 6'b110010)
               && (w[11:7] == 5'b0) && !w[4];
        quad = w[6];
        d    = {w[22], w[15:12]};
        m    = {w[5], w[3:0]};
        odd  = quad && (w[12] || w[0]);
        it.due = cyc + 1; it.req = req;
        it.acc = 0; it.und = 0; it.unp = 0;
        if (hit) begin
            if (!en || odd) it.und = 1;
            else if (d == m) begin it.acc = 1; it.unp = 1; end
            else begin
                it.acc = 1;
                t0 = mdl[d]; mdl[d] = mdl[m]; mdl[m] = t0;
                if (quad) begin
                    t1 = mdl[d+5'd1]; mdl[d+5'd1] = mdl[m+5'd1]; mdl[m+5'd1] = t1;
                end
            end
        end
        sb_q.push_back(it);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic load(input logic [4:0] a, input logic [63:0] v);
        ld_en = 1; ld_addr = a; ld_data = v;
        mdl[a] = v;
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic compare_rf(input string req);
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            ra_addr = 5'(i);
            rb_addr = 5'(31 - i);
            #1;
            check(req, $sformatf("reg A[%0d]", i), ra_data, mdl[i]);
            check(req, $sformatf("reg B[%0d]", 31 - i), rb_data, mdl[31 - i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; insn = '0; cmp_mode = 0; simd_en = 1;
        ld_en = 0; ld_addr = '0; ld_data = '0; ra_addr = '0; rb_addr = '0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        check("R9", "accepted", 64'(accepted), 0);
        check("R9", "undef", 64'(undef), 0);
        check("R9", "unpred", 64'(unpred), 0);
        compare_rf("R9");

        // R12: load distinct values
        for (int i = 0; i < 32; i++)
            load(5'(i), (64'(i) * 64'h0102_0304_0506_0709) ^ 64'hC0DE_5A5A_0000_0000 ^ 64'(i));
        compare_rf("R12");

        // R1 R3 R4: fixed-width doubleword swap
        issue(enc(0, 0, 5'd3, 5'd17), 0, 1, 1, "R4");
        compare_rf("R4");
        // R3: high-numbered registers use bit 22 and bit 5
        issue(enc(0, 0, 5'd31, 5'd16), 0, 1, 1, "R3");
        compare_rf("R3");
        // R1 R5: compact-encoding quadword swap
        issue(enc(1, 1, 5'd4, 5'd20), 1, 1, 1, "R1");
        compare_rf("R5");
        issue(enc(0, 1, 5'd30, 5'd0), 0, 1, 1, "R5");
        compare_rf("R5");

        // R2: other-mode prefix and corrupted fixed fields
        issue(enc(1, 0, 5'd1, 5'd2), 0, 1, 1, "R2");
        issue(enc(0, 0, 5'd1, 5'd2), 1, 1, 1, "R2");
        issue(enc(0, 0, 5'd1, 5'd2) | 32'h0000_0800, 0, 1, 1, "R2");
        issue(enc(0, 0, 5'd1, 5'd2) | 32'h0000_0010, 0, 1, 1, "R2");
        issue(enc(0, 0, 5'd1, 5'd2) ^ 32'h0002_0000, 0, 1, 1, "R2");
        compare_rf("R2");

        // R6: SIMD disabled
        issue(enc(0, 0, 5'd6, 5'd9), 0, 0, 1, "R6");
        compare_rf("R6");
        // R7: odd register in quadword form
        issue(enc(0, 1, 5'd5, 5'd8), 0, 1, 1, "R7");
        issue(enc(1, 1, 5'd8, 5'd9), 1, 1, 1, "R7");
        compare_rf("R7");
        // R8: same register
        issue(enc(0, 0, 5'd7, 5'd7), 0, 1, 1, "R8");
        issue(enc(0, 1, 5'd10, 5'd10), 0, 1, 1, "R8");
        compare_rf("R8");
        // R11: valid low
        issue(enc(0, 0, 5'd12, 5'd13), 0, 1, 0, "R11");
        compare_rf("R11");

        // R10: back-to-back instructions, each reads the previous result
        issue(enc(0, 0, 5'd1, 5'd2), 0, 1, 1, "R10");
        issue(enc(0, 0, 5'd2, 5'd3), 0, 1, 1, "R10");
        issue(enc(1, 1, 5'd2, 5'd24), 1, 1, 1, "R10");
        issue(enc(0, 0, 5'd9, 5'd9), 0, 1, 1, "R10");
        compare_rf("R10");

        // R12: swap wins over a same-cycle load of the same register
        ld_en = 1; ld_addr = 5'd14; ld_data = 64'hDEAD_BEEF_0000_0001;
        issue(enc(0, 0, 5'd14, 5'd15), 0, 1, 1, "R12");
        ld_en = 0;
        compare_rf("R12");

        // R9: reset mid-run
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        check("R9", "accepted", 64'(accepted), 0);
        check("R9", "undef", 64'(undef), 0);
        compare_rf("R9");

        repeat (3) @(negedge clk);
        check("R10", "scoreboard drained", 64'(sb_q.size()), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule